// File: doc/BRIEF.md
# Register Scoreboard Issue Controller

This block decides, once per cycle, whether the instruction waiting at the head of an in-order issue stage may be sent to its functional unit. It keeps one pending flag per general-purpose register. A flag that is clear means the register already holds its final value. A flag that is set means an instruction already sent off will still write that register. Issue stays in program order. The functional units may finish in any order, and each finished result clears its flag through one of several completion ports.

The issuing stage presents a destination register, two source registers and the index of the unit it wants. The controller compares all three register numbers against the flag array and checks the busy flag of the chosen unit. It then either raises a one-cycle dispatch strobe together with a one-hot unit select, or raises stall. While stall is high the requester keeps its request unchanged. A completion that arrives in the same cycle as the check already counts as cleared. Register 0 always reads as a constant, so it is never marked pending.

Top module: `sb_issue_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `pend_bits` becomes 0.
- R2: A valid request stalls (stall=1, dispatch=0) when the pending bit of `iss_src_a` or `iss_src_b` is set and no completion port clears that register in the same cycle (read-after-write).
- R3: A valid request stalls when the pending bit of `iss_dst` is set and no completion port clears it in the same cycle (write-after-write).
- R4: A valid request stalls when `fu_busy[iss_fu]` is 1, even if no register hazard exists.
- R5: When dispatch is 1, `disp_fu_sel` is the one-hot code of `iss_fu` (bit `iss_fu` set, all others 0); in all other cycles it is 0. After the edge that ends a dispatch cycle, `pend_bits[iss_dst]` is 1 if `iss_dst` is not 0.
- R6: A completion port k with `cpl_valid[k]`=1 clears `pend_bits[cpl_reg[k*5 +: 5]]` at the next edge. Ports that name different registers in the same cycle all take effect.
- R7: A register cleared by a completion port in the current cycle counts as not pending for that cycle's hazard check. If the same cycle dispatches an instruction whose destination is that register, the bit stays set (the new writer wins).
- R8: `pend_bits[0]` is always 0, and register 0 used as a source or destination never causes a stall.
- R9: dispatch and stall are never 1 together. When `iss_valid` is 1 exactly one of them is 1; when `iss_valid` is 0 both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | Head-of-issue instruction present |
| iss_dst | input | 5 | Destination register number |
| iss_src_a | input | 5 | First source register number |
| iss_src_b | input | 5 | Second source register number |
| iss_fu | input | 2 | Index of the requested functional unit |
| fu_busy | input | 4 | Per-unit busy flags, 1 = cannot accept |
| cpl_valid | input | 2 | Per completion port, result written back this cycle |
| cpl_reg | input | 10 | Register number per completion port, port k at bits k*5 +: 5 |
| dispatch | output | 1 | Instruction accepted this cycle |
| disp_fu_sel | output | 4 | One-hot unit select, valid with dispatch |
| stall | output | 1 | Request must be held |
| pend_bits | output | 32 | Pending flag per register |

## Verification
A flag wrongly left set shows up as a stall that never ends for any later reader or writer of that register. A flag wrongly cleared, or never set, lets a dependent instruction dispatch in the same cycle it is presented. Both errors also show on `pend_bits` one edge after the dispatch or completion that caused them. The bench therefore compares the whole flag array and the dispatch decision every cycle against its own model, so a divergence is reported at most one cycle after it arises.

// File: rtl/sb_issue_pkg.sv
// Package: shared types and helpers for the register scoreboard issue controller.
// Assumes register and unit counts are powers of two, chosen by the modules' parameters.
package sb_issue_pkg;

    // Reason a request cannot leave this cycle, in priority order.
    typedef enum logic [1:0] {
        HZ_NONE = 2'd0,
        HZ_RAW  = 2'd1,
        HZ_WAW  = 2'd2,
        HZ_BUSY = 2'd3
    } hz_kind_e;

    // One-hot mask of width 64 with bit idx set; callers slice what they need.
    function automatic logic [63:0] bit_at(input int unsigned idx);
        logic [63:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sb_clear_merge.sv
// Module: sb_clear_merge
// Folds all completion ports into one per-register clear mask for this cycle.
// Assumes each port carries a register number below NUM_REGS; register 0 may be named
// and is simply cleared again (it is never pending).
module sb_clear_merge #(
    parameter int NUM_REGS = 32,
    parameter int NUM_CPL  = 2,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_CPL-1:0]       cpl_valid,
    input  logic [NUM_CPL*REG_W-1:0] cpl_reg,
    output logic [NUM_REGS-1:0]      clr_mask
);
    import sb_issue_pkg::*;

    logic [NUM_REGS-1:0] port_mask [NUM_CPL];

    // Per-port decode of the register number into a one-hot clear vector.
    for (genvar k = 0; k < NUM_CPL; k++) begin : g_port
        always_comb begin
            port_mask[k] = '0;
            if (cpl_valid[k]) begin
                port_mask[k] = NUM_REGS'(bit_at(int'(cpl_reg[k*REG_W +: REG_W])));
            end
        end
    end

    // OR of all port vectors.
    always_comb begin
        clr_mask = '0;
        for (int k = 0; k < NUM_CPL; k++) begin
            clr_mask = clr_mask | port_mask[k];
        end
    end

endmodule

// File: rtl/sb_hazard_check.sv
// Module: sb_hazard_check
// Classifies the head-of-issue request against the pending flags seen after this
// cycle's completions, and against the busy flag of the requested unit.
// Assumes iss_fu is below NUM_FU. Priority of the reported reason: RAW, WAW, busy.
module sb_hazard_check #(
    parameter int NUM_REGS = 32,
    parameter int NUM_FU   = 4,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int FU_W    = $clog2(NUM_FU)
) (
    input  logic [NUM_REGS-1:0]    pend,
    input  logic [NUM_REGS-1:0]    clr_mask,
    input  logic [REG_W-1:0]       dst,
    input  logic [REG_W-1:0]       src_a,
    input  logic [REG_W-1:0]       src_b,
    input  logic [FU_W-1:0]        fu,
    input  logic [NUM_FU-1:0]      fu_busy,
    output sb_issue_pkg::hz_kind_e hz
);
    import sb_issue_pkg::*;

    logic [NUM_REGS-1:0] live;
    logic                raw_hit;
    logic                waw_hit;
    logic                unit_hit;

    // Flags still outstanding once same-cycle completions are taken into account.
    always_comb live = pend & ~clr_mask;

    // Individual hazard conditions.
    always_comb begin
        raw_hit  = live[src_a] | live[src_b];
        waw_hit  = live[dst];
        unit_hit = fu_busy[fu];
    end

    // Prioritised reason code.
    always_comb begin
        if (raw_hit)       hz = HZ_RAW;
        else if (waw_hit)  hz = HZ_WAW;
        else if (unit_hit) hz = HZ_BUSY;
        else               hz = HZ_NONE;
    end

endmodule

// File: rtl/sb_pend_array.sv
// Module: sb_pend_array
// Holds one pending flag per register. Clears from completions, sets from dispatch;
// when both hit the same register in one cycle the set wins. Flag 0 is held at zero.
// Synchronous active-low reset empties the array.
module sb_pend_array #(
    parameter int NUM_REGS = 32,
    localparam int REG_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] clr_mask,
    input  logic                set_en,
    input  logic [REG_W-1:0]    set_idx,
    output logic [NUM_REGS-1:0] pend
);
    import sb_issue_pkg::*;

    logic [NUM_REGS-1:0] set_vec;
    logic [NUM_REGS-1:0] pend_nxt;

    // Decode of the register being claimed by a dispatch.
    always_comb set_vec = set_en ? NUM_REGS'(bit_at(int'(set_idx))) : '0;

    // Next-state: clear first, then set, register 0 forced empty.
    always_comb begin
        pend_nxt    = (pend & ~clr_mask) | set_vec;
        pend_nxt[0] = 1'b0;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end

    for (genvar r = 1; r < NUM_REGS; r++) begin : g_chk
        AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[r]) |-> $past(set_en && (set_idx == REG_W'(r)))); // R5
        AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[r] && !(set_en && (set_idx == REG_W'(r)))) |=> !pend[r]); // R6
    end

endmodule

// File: rtl/sb_issue_ctrl.sv
// Module: sb_issue_ctrl (top)
// In-order issue gate for out-of-order completing functional units. Checks the
// head-of-issue request against a per-register pending array and the unit busy
// flags; dispatches or stalls. Assumes the requester holds its request while stall
// is high, and that at most one dispatch happens per cycle.
module sb_issue_ctrl #(
    parameter int NUM_REGS = 32,
    parameter int NUM_FU   = 4,
    parameter int NUM_CPL  = 2,
    localparam int REG_W   = $clog2(NUM_REGS),
    localparam int FU_W    = $clog2(NUM_FU)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     iss_valid,
    input  logic [REG_W-1:0]         iss_dst,
    input  logic [REG_W-1:0]         iss_src_a,
    input  logic [REG_W-1:0]         iss_src_b,
    input  logic [FU_W-1:0]          iss_fu,
    input  logic [NUM_FU-1:0]        fu_busy,
    input  logic [NUM_CPL-1:0]       cpl_valid,
    input  logic [NUM_CPL*REG_W-1:0] cpl_reg,
    output logic                     dispatch,
    output logic [NUM_FU-1:0]        disp_fu_sel,
    output logic                     stall,
    output logic [NUM_REGS-1:0]      pend_bits
);
    import sb_issue_pkg::*;

    logic [NUM_REGS-1:0] clr_mask;
    hz_kind_e            hz;
    logic                go;

    sb_clear_merge #(.NUM_REGS(NUM_REGS), .NUM_CPL(NUM_CPL)) i_clr (
        .cpl_valid (cpl_valid),
        .cpl_reg   (cpl_reg),
        .clr_mask  (clr_mask)
    );

    sb_hazard_check #(.NUM_REGS(NUM_REGS), .NUM_FU(NUM_FU)) i_haz (
        .pend     (pend_bits),
        .clr_mask (clr_mask),
        .dst      (iss_dst),
        .src_a    (iss_src_a),
        .src_b    (iss_src_b),
        .fu       (iss_fu),
        .fu_busy  (fu_busy),
        .hz       (hz)
    );

    // Accept/hold decision for the head request.
    always_comb begin
        go       = iss_valid && (hz == HZ_NONE);
        dispatch = go;
        stall    = iss_valid && (hz != HZ_NONE);
    end

    // One-hot steering toward the chosen unit.
    always_comb disp_fu_sel = go ? NUM_FU'(bit_at(int'(iss_fu))) : '0;

    sb_pend_array #(.NUM_REGS(NUM_REGS)) i_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mask (clr_mask),
        .set_en   (go),
        .set_idx  (iss_dst),
        .pend     (pend_bits)
    );

    AST_DEST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch && (iss_dst != '0)) |=> pend_bits[$past(iss_dst)]); // R5
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(disp_fu_sel) && (dispatch == (disp_fu_sel != '0))); // R5
    AST_NO_RAW_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> !((pend_bits[iss_src_a] && !clr_mask[iss_src_a]) ||
                       (pend_bits[iss_src_b] && !clr_mask[iss_src_b]))); // R2
    AST_NO_WAW_LEAK: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> !(pend_bits[iss_dst] && !clr_mask[iss_dst])); // R3
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> !fu_busy[iss_fu]); // R4
    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_bits[0]); // R8
    AST_STALL_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid == (dispatch ^ stall)) && !(dispatch && stall)); // R9
    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> (pend_bits == '0)); // R1

endmodule

// File: tb/test_sb_issue_ctrl.sv
// Bench: directed corner cases followed by seeded random traffic, compared each
// cycle with a flag-array model kept in the bench.
module test_sb_issue_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 32;
    localparam int NF = 4;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [4:0]    iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
    logic [1:0]    iss_fu = '0;
    logic [NF-1:0] fu_busy = '0;
    logic [NC-1:0] cpl_valid = '0;
    logic [9:0]    cpl_reg = '0;
    logic          dispatch, stall;
    logic [NF-1:0] disp_fu_sel;
    logic [NR-1:0] pend_bits;

    int checks = 0;
    int failures = 0;
    logic [NR-1:0] m_pend = '0;
    logic          last_stall = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_issue_ctrl i_sb_issue_ctrl (
        .clk, .rst_n, .iss_valid, .iss_dst, .iss_src_a, .iss_src_b, .iss_fu,
        .fu_busy, .cpl_valid, .cpl_reg, .dispatch, .disp_fu_sel, .stall, .pend_bits
    );

    function automatic logic [NR-1:0] clear_of(input logic [NC-1:0] v, input logic [9:0] rg);
        logic [NR-1:0] m = '0;
        if (v[0]) m[rg[4:0]] = 1'b1;
        if (v[1]) m[rg[9:5]] = 1'b1;
        return m;
    endfunction

    function automatic string reason_tag(input logic [NR-1:0] live, input logic busy);
        if (live[iss_src_a] || live[iss_src_b]) return "R2";
        if (live[iss_dst]) return "R3";
        if (busy) return "R4";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, compare, then advance the model.
    task automatic step(input logic v, input logic [4:0] d, input logic [4:0] a,
                        input logic [4:0] b, input logic [1:0] f, input logic [NF-1:0] bz,
                        input logic [NC-1:0] cv, input logic [9:0] cr, input string tag);
        logic [NR-1:0] clr, live;
        logic          exp_go;
        @(negedge clk);
        iss_valid = v; iss_dst = d; iss_src_a = a; iss_src_b = b; iss_fu = f;
        fu_busy = bz; cpl_valid = cv; cpl_reg = cr;
        #1;
        clr  = clear_of(cv, cr);
        live = m_pend & ~clr;
        exp_go = v && !live[a] && !live[b] && !live[d] && !bz[f];
        check({tag, " pend"}, 64'(pend_bits), 64'(m_pend));
        check({tag, " dispatch ", reason_tag(live, bz[f])}, 64'(dispatch), 64'(exp_go));
        check({tag, " stall R9"}, 64'(stall), 64'(v && !exp_go));
        check({tag, " fu_sel R5"}, 64'(disp_fu_sel), exp_go ? (64'd1 << f) : 64'd0);
        m_pend = live;
        if (exp_go && d != 0) m_pend[d] = 1'b1;
        last_stall = v && !exp_go;
    endtask

    initial begin
        logic [4:0] d, a, b;
        logic [1:0] f;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R1 reset pend", 64'(pend_bits), 64'd0);
        // R5: claim r5 on unit 2
        step(1, 5'd5, 5'd1, 5'd2, 2'd2, 4'b0000, 2'b00, 10'd0, "R5 first");
        // R2: read r5 while pending
        step(1, 5'd7, 5'd5, 5'd0, 2'd0, 4'b0000, 2'b00, 10'd0, "R2 raw");
        // R3: write r5 again
        step(1, 5'd5, 5'd0, 5'd0, 2'd1, 4'b0000, 2'b00, 10'd0, "R3 waw");
        // R4: unit 3 busy, no register hazard
        step(1, 5'd9, 5'd1, 5'd1, 2'd3, 4'b1000, 2'b00, 10'd0, "R4 busy");
        // R7: r5 completes while the writer to r5 waits -> dispatch, bit stays set
        step(1, 5'd5, 5'd5, 5'd0, 2'd1, 4'b0000, 2'b01, {5'd0, 5'd5}, "R7 bypass");
        step(1, 5'd6, 5'd0, 5'd0, 2'd0, 4'b0000, 2'b00, 10'd0, "R5 claim r6");
        // R6: both ports clear r5 and r6 together
        step(0, 5'd0, 5'd0, 5'd0, 2'd0, 4'b0000, 2'b11, {5'd6, 5'd5}, "R6 dual clear");
        step(1, 5'd11, 5'd5, 5'd6, 2'd0, 4'b0000, 2'b00, 10'd0, "R6 after clear");
        // R8: register 0 as destination, twice, never pending
        step(1, 5'd0, 5'd0, 5'd0, 2'd1, 4'b0000, 2'b00, 10'd0, "R8 r0 write");
        step(1, 5'd0, 5'd0, 5'd0, 2'd2, 4'b0000, 2'b00, 10'd0, "R8 r0 again");
        step(0, 5'd3, 5'd11, 5'd11, 2'd0, 4'b1111, 2'b00, 10'd0, "R9 idle");
        // Random phase, requests held while stalled.
        void'($urandom(32'd1234));
        d = 0; a = 0; b = 0; f = 0;
        for (int i = 0; i < 3000; i++) begin
            logic [NC-1:0] cv;
            logic [9:0]    cr;
            if (!last_stall) begin
                d = 5'($urandom_range(0, 15)); a = 5'($urandom_range(0, 15));
                b = 5'($urandom_range(0, 15)); f = 2'($urandom);
            end
            cv = 2'($urandom);
            cr = {5'($urandom_range(0, 15)), 5'($urandom_range(0, 15))};
            if (cr[9:5] == cr[4:0]) cv[1] = 1'b0;
            step(last_stall ? 1'b1 : 1'($urandom_range(0, 3) != 0), d, a, b, f,
                 4'($urandom) & 4'($urandom), cv, cr, "random");
        end
        // R1: reset in the middle of traffic empties the array.
        @(negedge clk); rst_n = 1'b0; iss_valid = 1'b0; cpl_valid = '0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 mid reset", 64'(pend_bits), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule